// File: doc/BRIEF.md
# Protected-register unlock sequencer

This block sits on the register bus beside a group of control registers that must not change by accident. The registers are locked out of reset. Software opens them by writing three fixed key bytes, in a set order, to a write-only key location. After the third correct byte, a status bit reads 1 and writes to protected registers take effect. While the block is locked, such writes are dropped without any error. Writing the key location while the block is unlocked closes the lock again.

The address decoder marks each access with a "target is protected" flag. The block returns a write-enable gate for those accesses. Three stub registers stand in for the guarded registers. One is fully protected, one is protected except for one bit, and one is unprotected. Each stub applies its own per-bit protection mask. This shows that protection can cover part of a register and leave the rest writable.

Top module: `prot_unlock_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), unlock_sts is 0, all stubs read 0 and any partial key progress is lost.
- R2: Writes of 0x59, 0x16 and 0x88 in that order to offset 0x100 raise unlock_sts on the edge of the third write. The key byte is wdata[7:0] and the upper data bits are ignored. unlock_sts does not rise on any other write.
- R3: While the block is locked, a key write that breaks the expected order returns the sequencer to idle. A key write of 0x59 at any step restarts the sequence at step one.
- R4: Writes to other addresses between key writes leave the sequence progress unchanged.
- R5: While unlock_sts is 0, protected stub bits keep their value on a write and prot_wr_ok is 0.
- R6: While unlock_sts is 1, prot_wr_ok equals bus_wr AND tgt_prot, and protected stub bits take the written data.
- R7: The stubs are at 0x010, 0x014 and 0x018. 0x010 is fully protected. At 0x014 every bit except bit 6 is protected. 0x018 has no protection. Bits without protection are written whatever the lock state.
- R8: Any key write while the block is unlocked, whatever its value, clears unlock_sts on that edge.
- R9: A read at 0x100 returns unlock_sts in bit 0 and zero in all other bits. Stub offsets return the stub value. Unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | ADDR_W (12) | Byte offset for the read or write |
| bus_wdata | input | DATA_W (32) | Write data |
| tgt_prot | input | 1 | Decoder flag: the current target is protected |
| rd_data | output | DATA_W (32) | Read data for bus_addr (combinational) |
| unlock_sts | output | 1 | 1 while protected writes are allowed |
| prot_wr_ok | output | 1 | Write-enable gate for protected registers |

## Verification
The bench builds the block with its default parameters: key bytes 0x59/0x16/0x88 at offset 0x100, and three 32-bit stubs whose masks are full, all-but-bit-6 and none. These defaults bring within reach the fully locked, partly locked and unlocked write paths in one run. The table-driven part steps through restarts, wrong bytes, interleaved foreign writes and relocking by any value. The directed tests cover upper data bits that are ignored and a reset that arrives part-way through the sequence.

// File: rtl/prot_pkg.sv
// Shared types for the protected-register unlock sequencer.
package prot_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_STEP1 = 2'd1,
        SEQ_STEP2 = 2'd2,
        SEQ_OPEN  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/prot_key_seq.sv
// Key sequencer: tracks the three-byte unlock order and holds the lock state.
// Assumes key_wr is high for exactly one cycle per key-register write.
module prot_key_seq
    import prot_pkg::*;
#(
    parameter int          KEY_W = 8,
    parameter logic [7:0]  KEY1  = 8'h59,
    parameter logic [7:0]  KEY2  = 8'h16,
    parameter logic [7:0]  KEY3  = 8'h88
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_byte,
    output logic             unlocked
);
    seq_state_t state_q, state_d;

    // Next-state choice for a key write.
    always_comb begin
        state_d = state_q;
        if (key_wr) begin
            if (state_q == SEQ_OPEN)
                state_d = SEQ_IDLE;
            else if (key_byte == KEY_W'(KEY1))
                state_d = SEQ_STEP1;
            else if (state_q == SEQ_STEP1 && key_byte == KEY_W'(KEY2))
                state_d = SEQ_STEP2;
            else if (state_q == SEQ_STEP2 && key_byte == KEY_W'(KEY3))
                state_d = SEQ_OPEN;
            else
                state_d = SEQ_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    assign unlocked = (state_q == SEQ_OPEN);
endmodule

// File: rtl/prot_stub_bank.sv
// Stub registers that stand in for guarded registers. Each stub has a
// per-bit protection mask. Masked bits change only while unlocked.
// Assumes stub offsets do not overlap other decoded offsets.
module prot_stub_bank #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int NUM    = 3,
    parameter int BASE   = 'h010,
    parameter int STRIDE = 4,
    parameter logic [NUM*DATA_W-1:0] PMASK = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  unlocked,
    output logic [NUM*DATA_W-1:0] stub_flat,
    output logic                  any_hit,
    output logic [DATA_W-1:0]     rd_val
);
    logic [NUM-1:0] hit;

    for (genvar i = 0; i < NUM; i++) begin : g_stub
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'(BASE + i*STRIDE);
        localparam logic [DATA_W-1:0] PM  = PMASK[i*DATA_W +: DATA_W];
        logic [DATA_W-1:0] q;
        logic [DATA_W-1:0] keep;

        assign hit[i] = (bus_addr == OFS);
        assign keep   = PM & {DATA_W{~unlocked}};

        // Stub storage: protected bits hold while locked.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (bus_wr && hit[i])
                q <= (q & keep) | (bus_wdata & ~keep);
        end

        assign stub_flat[i*DATA_W +: DATA_W] = q;
    end

    // Read mux over the stubs.
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM; i++)
            if (hit[i]) rd_val = stub_flat[i*DATA_W +: DATA_W];
    end

    assign any_hit = |hit;
endmodule

// File: rtl/prot_unlock_ctrl.sv
// Top of the unlock sequencer: decodes the key offset, gates protected
// writes and muxes read data. Assumes one bus access per cycle.
module prot_unlock_ctrl #(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32,
    parameter int          KEY_W    = 8,
    parameter int          KEY_OFS  = 'h100,
    parameter logic [7:0]  KEY1     = 8'h59,
    parameter logic [7:0]  KEY2     = 8'h16,
    parameter logic [7:0]  KEY3     = 8'h88,
    parameter int          NUM_STUB = 3,
    parameter int          STUB_BASE = 'h010,
    parameter logic [NUM_STUB*DATA_W-1:0] STUB_PMASK =
        {32'h0000_0000, 32'hFFFF_FFBF, 32'hFFFF_FFFF}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              tgt_prot,
    output logic [DATA_W-1:0] rd_data,
    output logic              unlock_sts,
    output logic              prot_wr_ok
);
    localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_OFS);

    logic                       key_hit;
    logic                       stub_hit;
    logic [DATA_W-1:0]          stub_rd;
    logic [NUM_STUB*DATA_W-1:0] stub_flat;

    assign key_hit = (bus_addr == KEY_A);

    prot_key_seq #(
        .KEY_W(KEY_W), .KEY1(KEY1), .KEY2(KEY2), .KEY3(KEY3)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (bus_wr && key_hit),
        .key_byte (bus_wdata[KEY_W-1:0]),
        .unlocked (unlock_sts)
    );

    prot_stub_bank #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM(NUM_STUB),
        .BASE(STUB_BASE), .STRIDE(4), .PMASK(STUB_PMASK)
    ) u_stubs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .unlocked  (unlock_sts),
        .stub_flat (stub_flat),
        .any_hit   (stub_hit),
        .rd_val    (stub_rd)
    );

    // Gate for protected targets outside this block.
    assign prot_wr_ok = bus_wr & tgt_prot & unlock_sts;

    // Read data: status bit only at the key offset, key itself reads zero.
    always_comb begin
        if (key_hit)       rd_data = {{(DATA_W-1){1'b0}}, unlock_sts};
        else if (stub_hit) rd_data = stub_rd;
        else               rd_data = '0;
    end
endmodule

// File: rtl/prot_unlock_chk.sv
// Checker bound to prot_unlock_ctrl: temporal rules of the lock.
module prot_unlock_chk #(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32,
    parameter int          KEY_OFS  = 'h100,
    parameter logic [7:0]  KEY3     = 8'h88,
    parameter int          NUM_STUB = 3,
    parameter logic [NUM_STUB*DATA_W-1:0] STUB_PMASK = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       unlock_sts,
    input  logic [DATA_W-1:0]          rd_data,
    input  logic [NUM_STUB*DATA_W-1:0] stub_flat
);
    logic key_wr;
    assign key_wr = bus_wr && (bus_addr == ADDR_W'(KEY_OFS));

    assert_reset_locked_R1: assert property (@(posedge clk)
        !rst_n |=> !unlock_sts);

    assert_open_only_on_third_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlock_sts && !(key_wr && bus_wdata[7:0] == KEY3)) |=> !unlock_sts);

    assert_locked_bits_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock_sts |=> ((stub_flat & STUB_PMASK) == $past(stub_flat & STUB_PMASK)));

    assert_relock_on_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_sts && key_wr) |=> !unlock_sts);

    assert_key_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(KEY_OFS)) |-> (rd_data[DATA_W-1:1] == '0));
endmodule

bind prot_unlock_ctrl prot_unlock_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_OFS(KEY_OFS), .KEY3(KEY3),
    .NUM_STUB(NUM_STUB), .STUB_PMASK(STUB_PMASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .unlock_sts(unlock_sts), .rd_data(rd_data),
    .stub_flat(stub_flat)
);

// File: tb/test_prot_unlock_ctrl.sv
module test_prot_unlock_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        tgt_prot = 0;
    logic [31:0] rd_data;
    logic        unlock_sts;
    logic        prot_wr_ok;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    prot_unlock_ctrl i_prot_unlock_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .tgt_prot(tgt_prot), .rd_data(rd_data),
        .unlock_sts(unlock_sts), .prot_wr_ok(prot_wr_ok)
    );

    // {addr[11:0], key byte[7:0], expected unlock after the write}
    localparam int NV = 20;
    localparam logic [20:0] VEC [NV] = '{
        {12'h100, 8'h59, 1'b0}, {12'h100, 8'h16, 1'b0}, {12'h100, 8'h88, 1'b1}, // R2
        {12'h100, 8'h00, 1'b0},                                                 // R8
        {12'h100, 8'h59, 1'b0}, {12'h100, 8'h59, 1'b0}, {12'h100, 8'h16, 1'b0}, // R3 restart
        {12'h010, 8'hAB, 1'b0}, {12'h100, 8'h88, 1'b1},                         // R4
        {12'h100, 8'h59, 1'b0},                                                 // R8 with key1
        {12'h100, 8'h59, 1'b0}, {12'h100, 8'h77, 1'b0}, {12'h100, 8'h16, 1'b0},
        {12'h100, 8'h88, 1'b0},                                                 // R3 wrong byte
        {12'h100, 8'h59, 1'b0}, {12'h100, 8'h16, 1'b0}, {12'h100, 8'h59, 1'b0},
        {12'h100, 8'h16, 1'b0}, {12'h100, 8'h88, 1'b1},                         // R3 restart at step 2
        {12'h100, 8'h11, 1'b0}                                                  // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write cycle; ok_exp is the expected prot_wr_ok during the access.
    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic p,
                      input int chk_ok, input logic ok_exp, input string req);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d; tgt_prot = p;
        #1;
        if (chk_ok != 0) check(req, 32'(prot_wr_ok), 32'(ok_exp));
        @(negedge clk);
        bus_wr = 0; tgt_prot = 0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        bus_wr = 0; bus_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 sts", 32'(unlock_sts), 0);
        rd(12'h010, 0, "R1 stub0");
        rd(12'h100, 0, "R9 key read locked");

        // table walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][20:9], {24'h0, VEC[i][8:1]}, 1'b0, 0, 1'b0, "");
            check($sformatf("R2/R3/R4/R8 vec%0d", i), 32'(unlock_sts), 32'(VEC[i][0]));
        end
        rd(12'h010, 0, "R5 stub0 untouched by vec write");

        // locked writes: R5, R7
        wr(12'h010, 32'hDEADBEEF, 1'b1, 1, 1'b0, "R5 gate low locked");
        rd(12'h010, 32'h0, "R5 stub0 held");
        wr(12'h014, 32'hFFFFFFFF, 1'b1, 0, 1'b0, "");
        rd(12'h014, 32'h0000_0040, "R7 open bit only");
        wr(12'h018, 32'h12345678, 1'b0, 0, 1'b0, "");
        rd(12'h018, 32'h12345678, "R7 unprotected stub");

        // unlock with junk in upper bits: R2
        wr(12'h100, 32'hFFFFFF59, 1'b0, 0, 1'b0, "");
        wr(12'h100, 32'hAAAA0016, 1'b0, 0, 1'b0, "");
        check("R2 not open before third", 32'(unlock_sts), 0);
        wr(12'h100, 32'h00000188, 1'b0, 0, 1'b0, "");
        check("R2 upper bits ignored", 32'(unlock_sts), 1);
        rd(12'h100, 32'h1, "R9 key read unlocked");

        // unlocked writes: R6
        wr(12'h010, 32'hDEADBEEF, 1'b1, 1, 1'b1, "R6 gate high");
        rd(12'h010, 32'hDEADBEEF, "R6 stub0 written");
        wr(12'h014, 32'h0, 1'b0, 1, 1'b0, "R6 gate needs tgt_prot");
        rd(12'h014, 32'h0, "R6 stub1 written");
        rd(12'h200, 32'h0, "R9 unmapped");

        // relock then reset mid-sequence: R8, R1
        wr(12'h100, 32'h0, 1'b0, 0, 1'b0, "");
        check("R8 relock", 32'(unlock_sts), 0);
        wr(12'h100, 32'h59, 1'b0, 0, 1'b0, "");
        wr(12'h100, 32'h16, 1'b0, 0, 1'b0, "");
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd(12'h010, 32'h0, "R1 stub cleared");
        wr(12'h100, 32'h88, 1'b0, 0, 1'b0, "");
        check("R1 progress lost", 32'(unlock_sts), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule